// File: doc/BRIEF.md
# Exponential Correlation Associative Recall Engine

This block is a programmable associative memory. Patterns are loaded into numbered slots while the block is idle. A recall begins with a probe word, which may be a corrupted version of a stored pattern. For every live slot the block counts the bit positions in which that slot agrees with the current state, and gives the slot a vote weight of two raised to that count. Each bit position adds up the votes in bipolar form: a stored 1 adds the weight and a stored 0 subtracts it. The sign of each sum gives the new state bit.

In single-step mode the block performs one such update. In feedback mode it feeds each result back as the next state. It stops when a step leaves the state unchanged, or when a fixed number of steps has been spent. Slots are visited one per clock and all bit sums are updated in parallel, so each step takes a fixed number of cycles. The full result word appears at once when the recall finishes.

Top module: `assoc_recall`

## Requirements
- R1: While busy_o is low, prog_we_i writes prog_data_i into slot prog_addr_i on the clock edge. While busy_o is high, prog_we_i is ignored and the stored slots are unchanged.
- R2: The similarity of a slot is the number of bit positions, out of 24, at which the slot equals the current state.
- R3: A slot's vote weight is 2^similarity. For bit i, the vote is added when the slot's bit i is 1 and subtracted when it is 0. The sums do not overflow, even with 32 fully matching slots.
- R4: Next-state bit i is 1 when its sum is zero or positive, and 0 when it is negative. An exact tie therefore yields 1.
- R5: Only slots with an index below slot_count_i take part in the vote. With a count of 0, every sum is zero and the result is all ones.
- R6: With feedback_i low, a recall performs exactly one update step. done_o rises 34 cycles after the cycle in which start_i was sampled. converged_o is 1 exactly when the result equals the probe.
- R7: With feedback_i high, each result becomes the next state until a step leaves the state unchanged. converged_o is then 1. The latency is 1 + 33 × (number of steps) cycles.
- R8: With feedback_i high, recall stops after MAX_ITER steps even when the state is still changing. converged_o is then 0, and state_o holds the last step's result.
- R9: start_i is ignored while busy_o is high. Neither the probe nor the timing of the running recall is affected.
- R10: After reset, busy_o, done_o, converged_o and state_o are all zero.
- R11: done_o is a single-cycle pulse during which busy_o is low. state_o and converged_o hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_we_i | input | 1 | Slot write strobe (accepted only while idle) |
| prog_addr_i | input | 5 | Slot index to write |
| prog_data_i | input | 24 | Pattern to store |
| slot_count_i | input | 6 | Number of live slots, counted from slot 0 |
| start_i | input | 1 | Recall start pulse |
| probe_i | input | 24 | Initial state for the recall |
| feedback_i | input | 1 | 1: iterate to a fixed point; 0: single step |
| busy_o | output | 1 | Recall in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| converged_o | output | 1 | The last step left the state unchanged |
| state_o | output | 24 | Recall result / current state |

## Verification
The bench targets the exact-tie case, using a pattern paired with its complement. A comparator that treated zero as negative would return all zeros there instead of all ones. It also loads every slot with the same pattern, so that the largest possible sum builds up; a narrow accumulator would wrap that sum and flip its sign. Slot counts of zero and of partial values catch a design that lets dead slots vote. Step-exact latency checks in both modes catch an off-by-one in the slot scan or extra feedback passes. A second instance with a step cap of one, together with start and write strobes issued mid-recall, exposes a design that ignores the cap, restarts on a second start, or corrupts storage while busy.

// File: rtl/assoc_recall_pkg.sv
package assoc_recall_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_THRESH
  } fsm_e;
endpackage

// File: rtl/pattern_store.sv
module pattern_store #(
  parameter int NUM_PAT = 32,
  parameter int PAT_W   = 24,
  parameter int IDX_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [PAT_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [PAT_W-1:0] rdata_o
);
  logic [PAT_W-1:0] mem_q [NUM_PAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_PAT; k++) mem_q[k] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/match_weigh.sv
module match_weigh #(
  parameter int PAT_W   = 24,
  parameter int MATCH_W = 5,
  parameter int ACC_W   = 31
) (
  input  logic [PAT_W-1:0]   pat_i,
  input  logic [PAT_W-1:0]   state_i,
  output logic [MATCH_W-1:0] match_o,
  output logic [ACC_W-1:0]   weight_o
);
  logic [PAT_W-1:0] agree;

  assign agree = ~(pat_i ^ state_i);

  always_comb begin
    match_o = '0;
    for (int b = 0; b < PAT_W; b++) match_o = match_o + MATCH_W'(agree[b]);
  end

  assign weight_o = ACC_W'(1) << match_o;
endmodule

// File: rtl/vote_accum.sv
module vote_accum #(
  parameter int PAT_W = 24,
  parameter int ACC_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [PAT_W-1:0] sign_i,
  input  logic [ACC_W-1:0] weight_i,
  output logic [PAT_W-1:0] nonneg_o
);
  for (genvar b = 0; b < PAT_W; b++) begin : g_bit
    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   acc_q <= '0;
      else if (clr_i) acc_q <= '0;
      else if (en_i)  acc_q <= sign_i[b] ? acc_q + weight_i : acc_q - weight_i;
    end

    // two's complement sign bit clear => sum >= 0
    assign nonneg_o[b] = ~acc_q[ACC_W-1];
  end
endmodule

// File: rtl/assoc_recall.sv
module assoc_recall
  import assoc_recall_pkg::*;
#(
  parameter int NUM_PAT  = 32,
  parameter int PAT_W    = 24,
  parameter int MAX_ITER = 16,
  parameter int IDX_W    = $clog2(NUM_PAT),
  parameter int CNT_W    = $clog2(NUM_PAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_we_i,
  input  logic [IDX_W-1:0] prog_addr_i,
  input  logic [PAT_W-1:0] prog_data_i,
  input  logic [CNT_W-1:0] slot_count_i,
  input  logic             start_i,
  input  logic [PAT_W-1:0] probe_i,
  input  logic             feedback_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             converged_o,
  output logic [PAT_W-1:0] state_o
);
  localparam int MATCH_W = $clog2(PAT_W + 1);
  localparam int ACC_W   = PAT_W + IDX_W + 2;
  localparam int ITER_W  = $clog2(MAX_ITER + 1);

  fsm_e             fsm_q;
  logic [PAT_W-1:0] state_q;
  logic [IDX_W-1:0] idx_q;
  logic [ITER_W-1:0] iter_q;
  logic             done_q;
  logic             conv_q;

  logic [PAT_W-1:0] slot_pat;
  logic [MATCH_W-1:0] match;
  logic [ACC_W-1:0] weight;
  logic [PAT_W-1:0] next_state;

  logic idle, accept, slot_live, idx_last, iter_last, same, go_on;

  assign idle      = (fsm_q == ST_IDLE);
  assign accept    = idle && start_i;
  assign slot_live = (CNT_W'(idx_q) < slot_count_i);
  assign idx_last  = (idx_q == IDX_W'(NUM_PAT - 1));
  assign iter_last = (iter_q == ITER_W'(MAX_ITER - 1));
  assign same      = (next_state == state_q);
  assign go_on     = (fsm_q == ST_THRESH) && feedback_i && !same && !iter_last;

  pattern_store #(.NUM_PAT(NUM_PAT), .PAT_W(PAT_W), .IDX_W(IDX_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (prog_we_i && idle),
    .waddr_i(prog_addr_i),
    .wdata_i(prog_data_i),
    .raddr_i(idx_q),
    .rdata_o(slot_pat)
  );

  match_weigh #(.PAT_W(PAT_W), .MATCH_W(MATCH_W), .ACC_W(ACC_W)) u_weigh (
    .pat_i   (slot_pat),
    .state_i (state_q),
    .match_o (match),
    .weight_o(weight)
  );

  vote_accum #(.PAT_W(PAT_W), .ACC_W(ACC_W)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept || go_on),
    .en_i    ((fsm_q == ST_SCAN) && slot_live),
    .sign_i  (slot_pat),
    .weight_i(weight),
    .nonneg_o(next_state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q   <= ST_IDLE;
      state_q <= '0;
      idx_q   <= '0;
      iter_q  <= '0;
      done_q  <= 1'b0;
      conv_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (fsm_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= probe_i;
            idx_q   <= '0;
            iter_q  <= '0;
            conv_q  <= 1'b0;
            fsm_q   <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          idx_q <= idx_q + 1'b1;
          if (idx_last) begin
            idx_q <= '0;
            fsm_q <= ST_THRESH;
          end
        end
        ST_THRESH: begin
          state_q <= next_state;
          if (go_on) begin
            iter_q <= iter_q + 1'b1;
            fsm_q  <= ST_SCAN;
          end else begin
            conv_q <= same;
            done_q <= 1'b1;
            fsm_q  <= ST_IDLE;
          end
        end
        default: fsm_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = !idle;
  assign done_o      = done_q;
  assign converged_o = conv_q;
  assign state_o     = state_q;
endmodule

// File: rtl/assoc_recall_chk.sv
module assoc_recall_chk #(
  parameter int PAT_W    = 24,
  parameter int MAX_ITER = 16,
  parameter int ITER_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              converged_o,
  input logic [PAT_W-1:0]  state_o,
  input logic [ITER_W-1:0] iter_q
);
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_state_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(state_o));

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  p_iter_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(iter_q) < MAX_ITER);

  p_conv_with_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(converged_o) |-> done_o);
endmodule

bind assoc_recall assoc_recall_chk #(
  .PAT_W(PAT_W), .MAX_ITER(MAX_ITER), .ITER_W(ITER_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .converged_o(converged_o),
  .state_o    (state_o),
  .iter_q     (iter_q)
);

// File: tb/assoc_recall_bench.sv
module assoc_recall_bench;
  localparam int NP = 32;
  localparam int W  = 24;
  localparam int MI = 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          we = 0;
  logic [4:0]    waddr = '0;
  logic [W-1:0]  wdata = '0;
  logic [5:0]    cnt = '0;
  logic          start = 0;
  logic [W-1:0]  probe = '0;
  logic          fb = 0;
  logic          busy, done, conv, c_busy, c_done, c_conv;
  logic [W-1:0]  st, c_st;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] mem_m [NP];
  int cnt_m = 0;

  always #10 clk = ~clk;

  assoc_recall #(.NUM_PAT(NP), .PAT_W(W), .MAX_ITER(MI)) u_assoc_recall (
    .clk_i(clk), .rst_ni(rst_n), .prog_we_i(we), .prog_addr_i(waddr),
    .prog_data_i(wdata), .slot_count_i(cnt), .start_i(start), .probe_i(probe),
    .feedback_i(fb), .busy_o(busy), .done_o(done), .converged_o(conv), .state_o(st));

  assoc_recall #(.NUM_PAT(NP), .PAT_W(W), .MAX_ITER(1)) u_assoc_recall_cap (
    .clk_i(clk), .rst_ni(rst_n), .prog_we_i(we), .prog_addr_i(waddr),
    .prog_data_i(wdata), .slot_count_i(cnt), .start_i(start), .probe_i(probe),
    .feedback_i(fb), .busy_o(c_busy), .done_o(c_done), .converged_o(c_conv), .state_o(c_st));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] step_m(input logic [W-1:0] s);
    logic [W-1:0] r;
    longint sum [W];
    for (int b = 0; b < W; b++) sum[b] = 0;
    for (int k = 0; k < NP; k++) begin
      if (k < cnt_m) begin
        int m = 0;
        longint w;
        for (int b = 0; b < W; b++) if (mem_m[k][b] == s[b]) m++;
        w = longint'(1) << m;
        for (int b = 0; b < W; b++) sum[b] += mem_m[k][b] ? w : -w;
      end
    end
    for (int b = 0; b < W; b++) r[b] = (sum[b] >= 0);
    return r;
  endfunction

  task automatic prog(input int a, input logic [W-1:0] d);
    @(negedge clk);
    we = 1; waddr = 5'(a); wdata = d;
    mem_m[a] = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic set_cnt(input int c);
    @(negedge clk);
    cnt = 6'(c); cnt_m = c;
  endtask

  // poke: issue start + slot-0 write while busy (R1, R9)
  task automatic recall(input logic [W-1:0] p, input bit f, input bit poke, input string tag);
    logic [W-1:0] s, n, e_st, c_exp;
    bit e_conv;
    int steps, lat;
    s = p; e_conv = 0; steps = 0;
    for (int it = 1; it <= MI; it++) begin
      n = step_m(s);
      steps = it;
      if (!f) begin e_conv = (n == s); s = n; break; end
      if (n == s) begin e_conv = 1; break; end
      s = n;
    end
    e_st = s;
    c_exp = step_m(p);
    @(negedge clk);
    probe = p; fb = f; start = 1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) start = 0;
      if (poke && lat == 5) begin
        start = 1; probe = ~p; we = 1; waddr = 0; wdata = ~mem_m[0];
      end
      if (poke && lat == 6) begin start = 0; we = 0; end
    end while (!done && lat < 2000);
    chk(st == e_st, {tag, " state"}, st, e_st);
    chk(conv == e_conv, {tag, " converged"}, conv, e_conv);
    chk(lat == 1 + 33 * steps, {tag, " latency"}, lat, 1 + 33 * steps);
    @(negedge clk);
    chk(!done && !busy, "R11 done single pulse", done, 0);
    chk(!c_busy && c_st == c_exp, "R8 cap state", c_st, c_exp);
    chk(c_conv == (c_exp == p), "R8 cap converged", c_conv, (c_exp == p));
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] x;
    logic [W-1:0] msk, a;
    for (int k = 0; k < NP; k++) mem_m[k] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !conv && st == '0, "R10 reset state", st, 0);
    rst_n = 1;

    // R1 R2 R3: load random patterns
    x = 32'h1234_5678;
    for (int k = 0; k < NP; k++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      prog(k, x[W-1:0]);
    end
    set_cnt(32);

    // R2 R3 R7: noisy probes, feedback
    for (int p = 0; p < 8; p++) begin
      for (int f = 0; f < 4; f++) begin
        msk = '0;
        for (int j = 0; j < f; j++) msk[(p * 3 + j * 7) % W] = 1'b1;
        recall(mem_m[p] ^ msk, 1, 0, "R7 feedback recall");
      end
    end

    // R6: single step
    for (int p = 8; p < 14; p++) recall(mem_m[p] ^ 24'h00_0C03, 0, 0, "R6 single step");
    recall(24'h5A5A5A, 0, 0, "R6 single step arbitrary");

    // R5: live slot count sweep, including 0
    set_cnt(0);
    recall(24'h123456, 0, 0, "R5 zero count");
    chk(st == 24'hFFFFFF, "R5 zero count all ones", st, 24'hFFFFFF);
    foreach (mem_m[k]) if (k == 0) ;
    for (int c = 1; c < 32; c += 6) begin
      set_cnt(c);
      recall(mem_m[c] ^ 24'h000101, 0, 0, "R5 partial count");
      recall(mem_m[31] ^ 24'h010000, 1, 0, "R5 partial count fb");
    end

    // R1: write then read back via count=1
    prog(0, 24'hC3A5_0F);
    set_cnt(1);
    recall(24'h000000, 0, 0, "R1 write readback");
    chk(st == 24'hC3A50F, "R1 written slot", st, 24'hC3A50F);

    // R9 R1: start and write while busy are ignored
    set_cnt(32);
    a = mem_m[0];
    recall(a ^ 24'h000011, 1, 1, "R9 start ignored");
    mem_m[0] = a;
    set_cnt(1);
    recall(24'hFFFFFF, 0, 0, "R1 busy write ignored");
    chk(st == a, "R1 slot unchanged", st, a);

    // R4: exact tie, pattern vs its complement
    a = 24'h9C3_6E1;
    prog(0, a);
    prog(1, ~a);
    set_cnt(2);
    recall(a ^ 24'h000FFF, 0, 0, "R4 tie");
    chk(st == 24'hFFFFFF, "R4 tie resolves to one", st, 24'hFFFFFF);

    // R3: 32 identical full matches, max magnitude
    a = 24'hB1_7E_24;
    for (int k = 0; k < NP; k++) prog(k, a);
    set_cnt(32);
    recall(a, 0, 0, "R3 max sum");
    chk(st == a, "R3 no overflow", st, a);
    recall(a, 1, 0, "R3 max sum fb");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule